// File: doc/BRIEF.md
# Banked Memory Fault Flag Collector

This block gathers fault events reported by the ECC pipelines of a banked on-chip RAM and turns them into sticky flags and one interrupt line. Each bank raises four kinds of event: a corrected single-bit error, an uncorrectable multi-bit error, a write-strobe error and an access error. With four banks this gives a 16-flag matrix. Two masks gate the matrix at different points. A latch mask decides which raw events may set a flag at all. An interrupt mask decides which set flags reach the interrupt output.

Software reads and writes three registers through a small synchronous port. Flags are cleared by writing ones to them. The block also has a combinational probe that tells which bank holds a given byte address. The RAM is interleaved in 8-byte words across a 32-byte stride, so address bits [4:3] name the bank. The ECC encode and decode logic sits outside this block.

Top module: `bank_fault_hub`

## Requirements
- R1: Flag bit positions are fixed by kind and bank: bits 3:0 are single-bit errors of banks 0..3, bits 7:4 are multi-bit errors, bits 11:8 are strobe errors, and bits 15:12 are access errors. In each group, bit k belongs to bank k.
- R2: When an event input is high at a clock edge and its latch-mask bit is 1, the matching flag reads 1 from that edge onward.
- R3: An event whose latch-mask bit is 0 leaves its flag unchanged at 0.
- R4: `irq_o` is high exactly when some flag is 1 and its interrupt-mask bit is also 1. It follows the flags with no added cycle.
- R5: A write to the flag register at offset 0 clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R6: Writing 0xFFFF to offset 0 clears all 16 flags.
- R7: If a write-one-to-clear and a new enabled event hit the same flag at the same edge, the flag stays 1.
- R8: `probe_bank` equals `probe_addr[4:3]`, which is the bank of an address under 8-byte interleaving over a 32-byte stride. Address bits [2:0] and all bits above bit 4 have no effect.
- R9: After reset the flags are 0, the interrupt mask is 0, `irq_o` is low, and the latch mask is 0xFFFF.
- R10: Register offsets are 0 for flags, 1 for the latch mask and 2 for the interrupt mask. Masks are plain read/write. Offset 3 reads as 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_single | input | 4 | Single-bit error event, one bit per bank |
| ev_multi | input | 4 | Multi-bit error event, one bit per bank |
| ev_strobe | input | 4 | Write-strobe error event, one bit per bank |
| ev_access | input | 4 | Access error event, one bit per bank |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| irq_o | output | 1 | Interrupt request |
| probe_addr | input | 32 | Byte address to classify |
| probe_bank | output | 2 | Bank that holds probe_addr |

## Verification
The bench goes after four corner cases.
- It fires an event and a write-one-to-clear at the same flag in the same cycle. A design that lets the clear win would lose the event and read that flag as 0.
- It writes zeros to the flag register and expects no change. A design that loads the register instead of clearing selected bits would wipe every flag.
- It masks one latch bit and fires every event at once. A design that gates at the interrupt rather than at the latch, or that misplaces a kind group, shows the masked flag set or another flag missing.
- It drives the probe with addresses whose low three bits and upper bits vary. A decoder that takes the wrong bit slice returns the wrong bank.

// File: rtl/fault_hub_pkg.sv
package fault_hub_pkg;
   // register offsets on the software port
   typedef enum logic [1:0] {
      OFS_FLAGS    = 2'd0,
      OFS_LATCH_EN = 2'd1,
      OFS_IRQ_EN   = 2'd2,
      OFS_SPARE    = 2'd3
   } hub_reg_e;

   localparam int unsigned REG_AW    = 2;
   localparam int unsigned NUM_KINDS = 4;
   // group order inside the flag vector, lowest group first
   localparam int unsigned KIND_SINGLE = 0;
   localparam int unsigned KIND_MULTI  = 1;
   localparam int unsigned KIND_STROBE = 2;
   localparam int unsigned KIND_ACCESS = 3;
endpackage

// File: rtl/fault_flag_array.sv
module fault_flag_array #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] hit,
   input  logic [WIDTH-1:0] latch_en,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] flags
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("fault_flag_array: WIDTH must be at least 1");
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic take;
         assign take = hit[i] & latch_en[i];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           flags[i] <= 1'b0;
            else if (take)        flags[i] <= 1'b1;  // new event beats clear
            else if (clr_mask[i]) flags[i] <= 1'b0;
         end

         AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && latch_en[i]) |=> flags[i]); // R2
         AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (!latch_en[i] && !flags[i]) |=> !flags[i]); // R3
         AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_mask[i] && !(hit[i] && latch_en[i])) |=> !flags[i]); // R5
         AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr_mask[i]) |=> flags[i]); // R5
         AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_mask[i] && hit[i] && latch_en[i]) |=> flags[i]); // R7
      end
   endgenerate
endmodule

// File: rtl/lane_bank_decode.sv
module lane_bank_decode #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LANE_BYTES = 8,
   parameter int unsigned NUM_BANKS  = 4
) (
   input  logic [ADDR_W-1:0]                       addr,
   output logic [$clog2(NUM_BANKS)-1:0]            bank
);
   localparam int unsigned LSB = $clog2(LANE_BYTES);
   localparam int unsigned BB  = $clog2(NUM_BANKS);

   generate
      if ((LANE_BYTES & (LANE_BYTES - 1)) != 0 || LANE_BYTES < 2) begin : g_bad_lane
         $error("lane_bank_decode: LANE_BYTES must be a power of two >= 2");
      end
      if ((NUM_BANKS & (NUM_BANKS - 1)) != 0 || NUM_BANKS < 2) begin : g_bad_banks
         $error("lane_bank_decode: NUM_BANKS must be a power of two >= 2");
      end
      if (LSB + BB > ADDR_W) begin : g_bad_addr
         $error("lane_bank_decode: ADDR_W too narrow for the stride");
      end
   endgenerate

   assign bank = addr[LSB +: BB];

   logic unused_addr_bits;
   assign unused_addr_bits = ^{addr[LSB-1:0], addr[ADDR_W-1:LSB+BB]};
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
   parameter int unsigned WIDTH      = 16,
   parameter bit          REGISTERED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] flags,
   input  logic [WIDTH-1:0] irq_en,
   output logic             irq
);
   logic any_live;
   assign any_live = |(flags & irq_en);

   generate
      if (REGISTERED) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= any_live;
         end
         assign irq = irq_q;
         AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (flags == '0) |=> !irq); // R4
      end else begin : g_comb
         assign irq = any_live;
         AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (flags == '0 || irq_en == '0) |-> !irq); // R4
      end
   endgenerate
endmodule

// File: rtl/bank_fault_hub.sv
module bank_fault_hub
   import fault_hub_pkg::*;
#(
   parameter int unsigned NUM_BANKS    = 4,
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned LANE_BYTES   = 8,
   parameter bit          LATCH_ALL_RST = 1'b1,
   parameter bit          IRQ_REGISTERED = 1'b0,
   localparam int unsigned FLAG_W = NUM_KINDS * NUM_BANKS,
   localparam int unsigned BANK_W = $clog2(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_BANKS-1:0] ev_single,
   input  logic [NUM_BANKS-1:0] ev_multi,
   input  logic [NUM_BANKS-1:0] ev_strobe,
   input  logic [NUM_BANKS-1:0] ev_access,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [FLAG_W-1:0] reg_wdata,
   output logic [FLAG_W-1:0] reg_rdata,
   output logic              irq_o,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic [BANK_W-1:0] probe_bank
);
   hub_reg_e sel;
   assign sel = hub_reg_e'(reg_addr);

   // event matrix, one group of NUM_BANKS per kind
   logic [FLAG_W-1:0] hit;
   assign hit[KIND_SINGLE*NUM_BANKS +: NUM_BANKS] = ev_single;
   assign hit[KIND_MULTI *NUM_BANKS +: NUM_BANKS] = ev_multi;
   assign hit[KIND_STROBE*NUM_BANKS +: NUM_BANKS] = ev_strobe;
   assign hit[KIND_ACCESS*NUM_BANKS +: NUM_BANKS] = ev_access;

   logic [FLAG_W-1:0] latch_en_q, irq_en_q, flags, clr_mask;

   assign clr_mask = (reg_we && sel == OFS_FLAGS) ? reg_wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_en_q <= LATCH_ALL_RST ? '1 : '0;
         irq_en_q   <= '0;
      end else if (reg_we) begin
         if (sel == OFS_LATCH_EN) latch_en_q <= reg_wdata;
         if (sel == OFS_IRQ_EN)   irq_en_q   <= reg_wdata;
      end
   end

   always_comb begin
      unique case (sel)
         OFS_FLAGS:    reg_rdata = flags;
         OFS_LATCH_EN: reg_rdata = latch_en_q;
         OFS_IRQ_EN:   reg_rdata = irq_en_q;
         default:      reg_rdata = '0;
      endcase
   end

   fault_flag_array #(.WIDTH(FLAG_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .hit(hit), .latch_en(latch_en_q),
      .clr_mask(clr_mask), .flags(flags)
   );

   irq_merge #(.WIDTH(FLAG_W), .REGISTERED(IRQ_REGISTERED)) u_irq (
      .clk(clk), .rst_n(rst_n), .flags(flags), .irq_en(irq_en_q), .irq(irq_o)
   );

   lane_bank_decode #(.ADDR_W(ADDR_W), .LANE_BYTES(LANE_BYTES), .NUM_BANKS(NUM_BANKS)) u_dec (
      .addr(probe_addr), .bank(probe_bank)
   );

   AST_SPARE_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && sel == OFS_SPARE) |=> ($stable(latch_en_q) && $stable(irq_en_q))); // R10
   AST_SPARE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == OFS_SPARE) |-> (reg_rdata == '0)); // R10
endmodule

// File: tb/sim_bank_fault_hub.sv
module sim_bank_fault_hub;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  ev_single = '0, ev_multi = '0, ev_strobe = '0, ev_access = '0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq_o;
   logic [31:0] probe_addr = '0;
   logic [1:0]  probe_bank;

   always #10 clk = ~clk;  // 50 MHz

   bank_fault_hub u0 (
      .clk(clk), .rst_n(rst_n), .ev_single(ev_single), .ev_multi(ev_multi),
      .ev_strobe(ev_strobe), .ev_access(ev_access), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_o(irq_o), .probe_addr(probe_addr), .probe_bank(probe_bank)
   );

   typedef struct {
      int          what;   // 0 read data, 1 interrupt, 2 bank probe
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb_q[$];
   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // monitor: pops expected items and compares away from the clock edge
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sb_q.pop_front();
         case (it.what)
            0:       act = {16'h0, reg_rdata};
            1:       act = {31'h0, irq_o};
            default: act = {30'h0, probe_bank};
         endcase
         n_checks++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
         end
      end
   end

   task automatic settle();
      @(negedge clk); #1;
   endtask

   task automatic expect_reg(input logic [1:0] a, input logic [15:0] e, input string tag);
      reg_addr = a;
      sb_q.push_back('{0, {16'h0, e}, tag});
      settle();
   endtask

   task automatic expect_irq(input logic e, input string tag);
      sb_q.push_back('{1, {31'h0, e}, tag});
      settle();
   endtask

   task automatic expect_bank(input logic [31:0] a, input logic [1:0] e, input string tag);
      probe_addr = a;
      sb_q.push_back('{2, {30'h0, e}, tag});
      settle();
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(posedge clk); #2;
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #2;
      reg_we = 1'b0;
   endtask

   task automatic pulse(input logic [3:0] s, input logic [3:0] m,
                        input logic [3:0] st, input logic [3:0] ac);
      @(posedge clk); #2;
      ev_single = s; ev_multi = m; ev_strobe = st; ev_access = ac;
      @(posedge clk); #2;
      ev_single = '0; ev_multi = '0; ev_strobe = '0; ev_access = '0;
   endtask

   initial begin
      #(20 * 50000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      settle();

      // R9 reset state
      expect_reg(2'd0, 16'h0000, "R9 flags after reset");
      expect_reg(2'd1, 16'hFFFF, "R9 latch mask after reset");
      expect_reg(2'd2, 16'h0000, "R9 irq mask after reset");
      expect_irq(1'b0, "R9 irq low after reset");

      // R1 R2 single error on bank 2 -> bit 2; R4 irq stays low while masked
      pulse(4'b0100, 4'b0, 4'b0, 4'b0);
      expect_reg(2'd0, 16'h0004, "R1 R2 single bank2 flag");
      expect_irq(1'b0, "R4 irq masked off");

      wr(2'd2, 16'h0004);
      expect_reg(2'd2, 16'h0004, "R10 irq mask readback");
      expect_irq(1'b1, "R4 irq on enabled flag");

      // R5 writing zero keeps flags
      wr(2'd0, 16'h0000);
      expect_reg(2'd0, 16'h0004, "R5 zero write keeps flag");
      expect_irq(1'b1, "R5 irq kept");
      wr(2'd0, 16'h0004);
      expect_reg(2'd0, 16'h0000, "R5 one clears flag");
      expect_irq(1'b0, "R4 irq drops with flag");

      // R3 masked multi bank1 (bit 5); R1 access bank3 -> bit 15
      wr(2'd1, 16'hFFDF);
      expect_reg(2'd1, 16'hFFDF, "R10 latch mask readback");
      pulse(4'b0, 4'b0010, 4'b0, 4'b1000);
      expect_reg(2'd0, 16'h8000, "R3 masked event ignored, R1 access bank3");

      // R1 all events at once with one masked bit
      pulse(4'hF, 4'hF, 4'hF, 4'hF);
      expect_reg(2'd0, 16'hFFDF, "R1 R3 full matrix");
      wr(2'd2, 16'hFFFF);
      expect_irq(1'b1, "R4 irq all enabled");
      wr(2'd0, 16'hFFFF);
      expect_reg(2'd0, 16'h0000, "R6 clear all");
      expect_irq(1'b0, "R6 irq low after clear all");

      // R7 event beats clear at same edge
      pulse(4'b0010, 4'b0, 4'b0, 4'b0);
      expect_reg(2'd0, 16'h0002, "R7 setup bank1 single");
      @(posedge clk); #2;
      ev_single = 4'b0001; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0003;
      @(posedge clk); #2;
      ev_single = '0; reg_we = 1'b0;
      expect_reg(2'd0, 16'h0001, "R7 event wins, other bit cleared");
      expect_irq(1'b1, "R7 irq from surviving flag");

      // R10 spare offset
      wr(2'd3, 16'hFFFF);
      expect_reg(2'd3, 16'h0000, "R10 spare reads zero");
      expect_reg(2'd0, 16'h0001, "R10 spare write leaves flags");
      expect_reg(2'd1, 16'hFFDF, "R10 spare write leaves latch mask");
      expect_reg(2'd2, 16'hFFFF, "R10 spare write leaves irq mask");

      // R8 bank decode
      expect_bank(32'h2024_0000, 2'd0, "R8 bank0");
      expect_bank(32'h2024_0008, 2'd1, "R8 bank1");
      expect_bank(32'h2024_0017, 2'd2, "R8 bank2 low bits ignored");
      expect_bank(32'h2024_001F, 2'd3, "R8 bank3");
      expect_bank(32'h2024_0020, 2'd0, "R8 next stride bank0");
      expect_bank(32'hFFFF_FFFA, 2'd3, "R8 upper bits ignored");

      settle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule